// File: doc/BRIEF.md
# Paged Nibble RAM Controller

This block is the data memory of a small microcontroller core whose datapath is four bits wide. It holds six pages of 56 general-purpose nibble cells, 336 cells in all. A page register picks which page the CPU's direct accesses reach. In every page, the lowest eight addresses are not RAM. They lead to one shared set of special registers: six pointer registers and two data-window registers.

Indexed access goes through the data windows. Window 0 combines pointers 0 and 1 into a 6-bit in-page address, and window 1 combines pointers 2 and 3 in the same way. In each pair, the odd pointer gives the two high bits and the even pointer gives the four low bits. A read or write of a window address is carried out at the location that its pointer pair names, in the currently selected page. That target may itself be one of the special registers.

Reads are registered. Read data appears one cycle after the read strobe and stays on the output until the next read. Writes take effect on the clock edge where the write strobe is high.

Top module: `paged_nibble_ram`

## Requirements
- R1: After reset the selected page is 0, all six pointer registers read 0, and `cpu_rdata` is 0.
- R2: A `page_wr` carrying a value from 0 to 5 makes that value the selected page, visible on `cur_page` after the next clock edge. `cur_page` never leaves 0 to 5.
- R3: A `page_wr` carrying 6 or 7 is ignored, and the previous page stays selected.
- R4: Addresses 0x08 to 0x3F reach RAM in the selected page, and each page keeps its own cells. Read data is on `cpu_rdata` in the cycle after `cpu_rd` is high, and it holds while no further read is issued.
- R5: Addresses 0x00 to 0x05 reach pointer registers 0 to 5. These are the same registers whatever page is selected.
- R6: Address 0x06 is data window 0. An access there acts on in-page address {pointer1[1:0], pointer0} in the selected page, and bits 3:2 of pointer 1 are ignored.
- R7: Address 0x07 is data window 1. An access there acts on in-page address {pointer3[1:0], pointer2}. The two channels are independent.
- R8: An indexed address below 0x06 reaches the corresponding shared pointer register, for both read and write.
- R9: An indexed address of 0x06 or 0x07 (a window aimed at a window) reads 0, and its write changes no register or RAM cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 6 | In-page address of the CPU access |
| cpu_wdata | input | 4 | Write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 4 | Registered read data |
| page_wr | input | 1 | Page register write strobe |
| page_wdata | input | 3 | New page number |
| cur_page | output | 3 | Currently selected page |

## Verification
The bench uses the same in-page address in several pages, so a design that dropped the page from the RAM index would show one page's data in another. It writes a pointer in one page and reads it back in another, which catches special registers kept per page. It loads the odd pointers with nonzero upper bits and runs both windows in turn; a wrong bit slice or crossed channels would read the wrong cell. It also aims a window at a pointer register and at the other window, where a design that fell through to RAM or let the write land would return stale data instead of the pointer value or zero.

// File: rtl/nram_pkg.sv
`timescale 1ns/1ps
package nram_pkg;
  localparam int NRAM_NIB_W  = 4;
  localparam int NRAM_PAGES  = 6;
  localparam int NRAM_ADDR_W = 6;
  localparam int NRAM_SPEC_N = 8;

  // Where the registered read data comes from
  typedef enum logic [1:0] {
    SRC_NULL = 2'd0,
    SRC_SPEC = 2'd1,
    SRC_RAM  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/nram_page_sel.sv
`timescale 1ns/1ps
module nram_page_sel #(
  parameter int PAGES  = 6,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  output logic [PAGE_W-1:0] page,
  output logic              load_ok
);
  function automatic logic page_legal(input logic [PAGE_W-1:0] p);
    return int'(p) < PAGES;
  endfunction

  assign load_ok = wr_en && page_legal(wr_page);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page <= '0;
    end else if (load_ok) begin
      page <= wr_page;
    end
  end
endmodule

// File: rtl/nram_ptr_file.sv
`timescale 1ns/1ps
module nram_ptr_file #(
  parameter int NIB_W  = 4,
  parameter int PTR_N  = 6,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 6,
  parameter int CHAN_N = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [SEL_W-1:0]              wr_sel,
  input  logic [NIB_W-1:0]              wr_data,
  input  logic [SEL_W-1:0]              rd_sel,
  output logic [NIB_W-1:0]              rd_data,
  output logic [CHAN_N-1:0][ADDR_W-1:0] idx_addr
);
  localparam int HI_W = ADDR_W - NIB_W;

  logic [NIB_W-1:0] ptr_q [PTR_N];

  // In-page address of an index channel: odd pointer low bits on top,
  // even pointer as the low nibble
  function automatic logic [ADDR_W-1:0] join_index(input logic [NIB_W-1:0] odd_p,
                                                   input logic [NIB_W-1:0] even_p);
    return {odd_p[HI_W-1:0], even_p};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PTR_N; i++) ptr_q[i] <= '0;
    end else if (wr_en && int'(wr_sel) < PTR_N) begin
      ptr_q[wr_sel] <= wr_data;
    end
  end

  assign rd_data = (int'(rd_sel) < PTR_N) ? ptr_q[rd_sel] : '0;

  for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
    assign idx_addr[c] = join_index(ptr_q[2*c+1], ptr_q[2*c]);
  end
endmodule

// File: rtl/nram_store.sv
`timescale 1ns/1ps
module nram_store #(
  parameter int NIB_W = 4,
  parameter int DEPTH = 336,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [NIB_W-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [NIB_W-1:0] rdata
);
  logic [NIB_W-1:0] mem [DEPTH];

  // Contents are not reset; a read in the same cycle as a write sees the old value
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/paged_nibble_ram.sv
`timescale 1ns/1ps
module paged_nibble_ram
  import nram_pkg::*;
#(
  parameter int NIB_W  = NRAM_NIB_W,
  parameter int PAGES  = NRAM_PAGES,
  parameter int ADDR_W = NRAM_ADDR_W,
  parameter int SPEC_N = NRAM_SPEC_N,
  localparam int PAGE_W = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [NIB_W-1:0]  cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [NIB_W-1:0]  cpu_rdata,
  input  logic              page_wr,
  input  logic [PAGE_W-1:0] page_wdata,
  output logic [PAGE_W-1:0] cur_page
);
  localparam int CELLS_PER_PAGE = (1 << ADDR_W) - SPEC_N;
  localparam int DEPTH          = PAGES * CELLS_PER_PAGE;
  localparam int IDX_W          = $clog2(DEPTH);
  localparam int SEL_W          = $clog2(SPEC_N);
  localparam int PTR_N          = SPEC_N - 2;
  localparam int CHAN_N         = 2;
  localparam int WIN0           = SPEC_N - 2;
  localparam int WIN1           = SPEC_N - 1;

  function automatic logic is_window(input logic [ADDR_W-1:0] a);
    return (int'(a) == WIN0) || (int'(a) == WIN1);
  endfunction

  function automatic logic [IDX_W-1:0] ram_slot(input logic [PAGE_W-1:0] pg,
                                                input logic [ADDR_W-1:0] a);
    return IDX_W'(int'(pg) * CELLS_PER_PAGE + int'(a) - SPEC_N);
  endfunction

  // Internal events brought out for the checker
  logic                          page_load_ok;
  logic [ADDR_W-1:0]             eff_addr;
  logic                          hit_ram;
  logic                          hit_spec;
  logic                          hit_null;
  logic [CHAN_N-1:0][ADDR_W-1:0] idx_addr;
  logic [NIB_W-1:0]              ptr_rd_data;
  logic [NIB_W-1:0]              ram_rdata;
  logic [IDX_W-1:0]              ram_idx;
  logic [NIB_W-1:0]              spec_q;
  rd_src_e                       src_q;

  nram_page_sel #(.PAGES(PAGES), .PAGE_W(PAGE_W)) u_page (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (page_wr),
    .wr_page (page_wdata),
    .page    (cur_page),
    .load_ok (page_load_ok)
  );

  // Resolve a window address into the location its pointer pair names
  always_comb begin
    if (int'(cpu_addr) == WIN0)      eff_addr = idx_addr[0];
    else if (int'(cpu_addr) == WIN1) eff_addr = idx_addr[1];
    else                             eff_addr = cpu_addr;
  end

  assign hit_null = is_window(eff_addr);
  assign hit_spec = (int'(eff_addr) < SPEC_N) && !hit_null;
  assign hit_ram  = int'(eff_addr) >= SPEC_N;
  assign ram_idx  = ram_slot(cur_page, eff_addr);

  nram_ptr_file #(
    .NIB_W  (NIB_W),
    .PTR_N  (PTR_N),
    .SEL_W  (SEL_W),
    .ADDR_W (ADDR_W),
    .CHAN_N (CHAN_N)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cpu_wr && hit_spec),
    .wr_sel   (eff_addr[SEL_W-1:0]),
    .wr_data  (cpu_wdata),
    .rd_sel   (eff_addr[SEL_W-1:0]),
    .rd_data  (ptr_rd_data),
    .idx_addr (idx_addr)
  );

  nram_store #(.NIB_W(NIB_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk   (clk),
    .we    (cpu_wr && hit_ram),
    .waddr (ram_idx),
    .wdata (cpu_wdata),
    .re    (cpu_rd && hit_ram),
    .raddr (ram_idx),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_NULL;
      spec_q <= '0;
    end else if (cpu_rd) begin
      if (hit_ram)       src_q <= SRC_RAM;
      else if (hit_spec) src_q <= SRC_SPEC;
      else               src_q <= SRC_NULL;
      if (hit_spec) spec_q <= ptr_rd_data;
    end
  end

  always_comb begin
    case (src_q)
      SRC_RAM:  cpu_rdata = ram_rdata;
      SRC_SPEC: cpu_rdata = spec_q;
      default:  cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nram_checker.sv
`timescale 1ns/1ps
module nram_checker #(
  parameter int NIB_W  = 4,
  parameter int PAGES  = 6,
  parameter int PAGE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic              page_wr,
  input logic [PAGE_W-1:0] page_wdata,
  input logic [PAGE_W-1:0] cur_page,
  input logic [NIB_W-1:0]  cpu_rdata,
  input logic              hit_ram,
  input logic              hit_spec,
  input logic              hit_null
);
  p_page_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_page) < PAGES);

  p_page_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (page_wr && int'(page_wdata) < PAGES) |=> cur_page == $past(page_wdata));

  p_page_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (page_wr && int'(page_wdata) >= PAGES) |=> $stable(cur_page));

  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> $stable(cpu_rdata));

  p_one_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd || cpu_wr) |-> $onehot({hit_ram, hit_spec, hit_null}));

  p_window_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && hit_null) |=> cpu_rdata == '0);
endmodule

bind paged_nibble_ram nram_checker #(
  .NIB_W  (NIB_W),
  .PAGES  (PAGES),
  .PAGE_W (PAGE_W)
) u_nram_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_rd     (cpu_rd),
  .cpu_wr     (cpu_wr),
  .page_wr    (page_wr),
  .page_wdata (page_wdata),
  .cur_page   (cur_page),
  .cpu_rdata  (cpu_rdata),
  .hit_ram    (hit_ram),
  .hit_spec   (hit_spec),
  .hit_null   (hit_null)
);

// File: tb/test_paged_nibble_ram.sv
`timescale 1ns/1ps
module test_paged_nibble_ram;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cpu_addr = '0;
  logic [3:0] cpu_wdata = '0;
  logic       cpu_rd = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [3:0] cpu_rdata;
  logic       page_wr = 1'b0;
  logic [2:0] page_wdata = '0;
  logic [2:0] cur_page;

  int checks = 0;
  int failures = 0;
  logic [3:0] exp_q [$];
  string      tag_q [$];
  logic       rd_seen = 1'b0;
  logic       done = 1'b0;

  always #10 clk = ~clk;

  paged_nibble_ram i_paged_nibble_ram (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .cpu_rdata  (cpu_rdata),
    .page_wr    (page_wr),
    .page_wdata (page_wdata),
    .cur_page   (cur_page)
  );

  task automatic check_val(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: a read strobe seen at a rising edge produces data checked at the next falling edge
  always @(posedge clk) rd_seen <= cpu_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL scoreboard: read data with no expected item, actual=%h expected=none", cpu_rdata);
      end else begin
        check_val(tag_q.pop_front(), cpu_rdata, exp_q.pop_front());
      end
    end
  end

  // Driver tasks start and end at a falling edge
  task automatic do_write(input logic [5:0] a, input logic [3:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic do_read(input logic [5:0] a, input logic [3:0] exp, input string tag);
    cpu_addr = a; cpu_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic set_page(input logic [2:0] p);
    page_wdata = p; page_wr = 1'b1;
    @(negedge clk);
    page_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: state during and right after reset
    check_val("R1 page in reset", {1'b0, cur_page}, 4'h0);
    check_val("R1 rdata in reset", cpu_rdata, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) do_read(6'(i), 4'h0, "R1 pointer reset");
    @(negedge clk);

    // R2 / R3: page selection
    set_page(3'd3);
    check_val("R2 page load 3", {1'b0, cur_page}, 4'h3);
    set_page(3'd6);
    check_val("R3 page 6 ignored", {1'b0, cur_page}, 4'h3);
    set_page(3'd7);
    check_val("R3 page 7 ignored", {1'b0, cur_page}, 4'h3);
    set_page(3'd5);
    check_val("R2 page load 5", {1'b0, cur_page}, 4'h5);

    // R4: per-page RAM, same addresses in every page
    for (int p = 0; p < 6; p++) begin
      set_page(3'(p));
      do_write(6'h08, 4'(p + 1));
      do_write(6'h3F, 4'(15 - p));
      do_write(6'h25, 4'(p * 2 + 3));
    end
    for (int p = 5; p >= 0; p--) begin
      set_page(3'(p));
      do_read(6'h08, 4'(p + 1), "R4 low cell");
      do_read(6'h3F, 4'(15 - p), "R4 top cell");
      do_read(6'h25, 4'(p * 2 + 3), "R4 mid cell");
    end
    // R4: data holds while no read is issued; page 0 top cell holds 15
    do_write(6'h3F, 4'h1);
    repeat (3) @(negedge clk);
    check_val("R4 rdata hold", cpu_rdata, 4'h3);

    // R5: pointer registers shared by all pages
    set_page(3'd1);
    do_write(6'h02, 4'hA);
    do_write(6'h05, 4'h6);
    set_page(3'd4);
    do_read(6'h02, 4'hA, "R5 shared pointer 2");
    do_read(6'h05, 4'h6, "R5 shared pointer 5");

    // R6: window 0 -> {p1[1:0], p0}; p1 = 0xE gives high bits 2, so 0x25
    set_page(3'd2);
    do_write(6'h00, 4'h5);
    do_write(6'h01, 4'hE);
    do_write(6'h06, 4'h9);
    do_read(6'h25, 4'h9, "R6 window 0 write lands at 0x25");
    do_read(6'h06, 4'h9, "R6 window 0 read");
    set_page(3'd3);
    do_read(6'h25, 4'h9, "R6 other page untouched");

    // R7: window 1 -> {p3[1:0], p2} = 0x3C in page 3
    do_write(6'h02, 4'hC);
    do_write(6'h03, 4'h3);
    do_write(6'h07, 4'h7);
    do_read(6'h3C, 4'h7, "R7 window 1 write lands at 0x3C");
    do_read(6'h07, 4'h7, "R7 window 1 read");
    do_write(6'h25, 4'h2);
    do_read(6'h06, 4'h2, "R7 channel 0 independent");

    // R8: window 0 aimed at pointer 4
    do_write(6'h00, 4'h4);
    do_write(6'h01, 4'h0);
    do_write(6'h06, 4'hB);
    do_read(6'h04, 4'hB, "R8 indexed write to pointer 4");
    do_read(6'h06, 4'hB, "R8 indexed read of pointer 4");

    // R9: window 0 aimed at window 1, then at itself
    do_write(6'h00, 4'h7);
    do_read(6'h06, 4'h0, "R9 window at other window reads 0");
    do_write(6'h06, 4'hF);
    do_read(6'h3C, 4'h7, "R9 discarded write left RAM");
    do_read(6'h07, 4'h7, "R9 discarded write left window 1");
    do_read(6'h02, 4'hC, "R9 discarded write left pointer 2");
    do_write(6'h00, 4'h6);
    do_read(6'h06, 4'h0, "R9 window at itself reads 0");
    do_write(6'h06, 4'h8);
    do_read(6'h00, 4'h6, "R9 self write left pointer 0");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule